// File: doc/BRIEF.md
# Block Address Translation Unit

This block maps effective addresses onto physical addresses for large, naturally aligned memory regions. It holds two banks of translation entries, one for data accesses and one for instruction fetches. Each entry is a pair of 32-bit words: an upper word with the effective base, a region-length code and two mode-valid bits, and a lower word with the physical base, four storage-attribute bits and a two-bit protection code. Software loads the words through a single register-write port.

The forward lookup port takes an effective address, a bank select, a privilege mode and a store flag. It returns a hit flag, the translated physical address, the entry's attribute and protection bits, and a protection-fault flag. A separate reverse port takes a physical address and returns the effective address that maps to it, using the data bank. Both lookups are purely combinational over the registered entries, and the lowest-numbered matching entry wins in both directions.

Top module: `bat_xlate`

## Requirements
- R1: While reset is held, and after it until entries are written, every entry is invalid: `lk_hit` and `rv_hit` are low and `lk_pa`, `rv_ea`, `lk_attr`, `lk_prot` and `lk_fault` are zero.
- R2: A write with `wr_en` high stores `wr_data` into the word chosen by `wr_upper` (1 = upper) of entry `wr_idx` in the bank chosen by `wr_instr` (1 = instruction). Lookups see the new value from the cycle after the write strobe, and still see the old value in the strobe cycle. Upper word layout: bits [31:17] effective base, bits [12:2] length code BL, bit 1 supervisor-valid, bit 0 user-valid.
- R3: Lower word layout: bits [31:17] physical base, bit 6 write-through, bit 5 cache-inhibit, bit 4 coherence, bit 3 guarded, bits [1:0] protection. On a hit `lk_attr` is {bit6, bit5, bit4, bit3} of the lower word and `lk_prot` is bits [1:0].
- R4: An entry spans (BL+1) x 128 KiB, with BL+1 a power of two from 1 to 2048. It covers effective addresses from its base through base + size - 1 inclusive; the address one above and the address one below miss.
- R5: On a hit the physical address is the physical base plus the offset of the effective address from the effective base. Bits [16:0] pass straight through, and address bits that fall inside the region mask come from the effective address.
- R6: In supervisor mode (`lk_super` = 1) an entry takes part only if its supervisor-valid bit is set. In user mode it takes part only if its user-valid bit is set.
- R7: When several entries match, the one with the lowest index supplies every output.
- R8: On a forward miss `lk_hit` is low, and `lk_pa`, `lk_attr`, `lk_prot` and `lk_fault` are zero.
- R9: `lk_instr` picks the bank used by the forward lookup. A lower-word write to the instruction bank with bit 3 (guarded) set clears both words of that instruction entry, and leaves the data bank unchanged.
- R10: `lk_fault` is high on a hit whose protection code is 00 (no access), or on a hit by a store (`lk_store` = 1) whose protection code has bit 0 set (read-only). Code 10 permits both loads and stores.
- R11: The reverse lookup uses the data bank. An entry takes part there if either of its valid bits is set. For the lowest-indexed entry whose physical range contains `rv_pa`, it returns `rv_hit` high and `rv_ea` = effective base + (`rv_pa` - physical base). With no match, `rv_hit` is low and `rv_ea` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_instr | input | 1 | Write bank: 1 instruction, 0 data |
| wr_upper | input | 1 | Word select: 1 upper, 0 lower |
| wr_idx | input | 2 | Entry index for the write |
| wr_data | input | 32 | Word to store |
| lk_instr | input | 1 | Lookup bank: 1 instruction, 0 data |
| lk_super | input | 1 | Lookup privilege: 1 supervisor, 0 user |
| lk_store | input | 1 | Lookup is a store |
| lk_ea | input | 32 | Effective address to translate |
| lk_hit | output | 1 | Forward lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 4 | Write-through, cache-inhibit, coherence, guarded |
| lk_prot | output | 2 | Protection code of the hit entry |
| lk_fault | output | 1 | Protection fault on a hit |
| rv_pa | input | 32 | Physical address for the reverse lookup |
| rv_hit | output | 1 | Reverse lookup hit |
| rv_ea | output | 32 | Effective address found by the reverse lookup |

## Verification
The bench builds the block with its default of four entries per bank and the fixed 32-bit address and 128 KiB minimum region. At that size it can place overlapping regions on every index, which exercises first-match priority at both ends of the scan. It can also cover region sizes from the smallest up to the largest length code. Directed cases probe the inclusive top and bottom limits, each privilege mode, every protection code, and the guarded-clears-instruction-entry rule. A randomized phase then reloads entries with aligned bases of random sizes, interleaved with forward and reverse lookups, all compared against a range-arithmetic model.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 17;                 // 128 KiB minimum region
  localparam int TAG_W  = ADDR_W - OFS_W;
  localparam int BL_W   = 11;                 // up to 256 MiB
  localparam int BL_LSB = 2;
  localparam int SV_BIT = 1;
  localparam int UV_BIT = 0;
  localparam int ATTR_W = 4;
  localparam int ATTR_LSB = 3;                // bits 6:3, guarded at bit 3
  localparam int GD_BIT = 3;
  localparam int PROT_W = 2;

  typedef logic [ADDR_W-1:0] word_t;
  typedef logic [TAG_W-1:0]  tag_t;
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
  import bat_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_instr,
  input  logic                    wr_upper,
  input  logic [IDX_W-1:0]        wr_idx,
  input  word_t                   wr_data,
  output logic [N_ENT-1:0][ADDR_W-1:0] d_up,
  output logic [N_ENT-1:0][ADDR_W-1:0] d_lo,
  output logic [N_ENT-1:0][ADDR_W-1:0] i_up,
  output logic [N_ENT-1:0][ADDR_W-1:0] i_lo
);
  logic [N_ENT-1:0][ADDR_W-1:0] d_up_q, d_lo_q, i_up_q, i_lo_q;
  logic [N_ENT-1:0][ADDR_W-1:0] d_up_n, d_lo_n, i_up_n, i_lo_n;

  always_comb begin
    d_up_n = d_up_q;
    d_lo_n = d_lo_q;
    i_up_n = i_up_q;
    i_lo_n = i_lo_q;
    if (wr_instr) begin
      if (!wr_upper && wr_data[GD_BIT]) begin
        // guarded instruction mapping is illegal: drop the entry
        i_up_n[wr_idx] = '0;
        i_lo_n[wr_idx] = '0;
      end else if (wr_upper) begin
        i_up_n[wr_idx] = wr_data;
      end else begin
        i_lo_n[wr_idx] = wr_data;
      end
    end else if (wr_upper) begin
      d_up_n[wr_idx] = wr_data;
    end else begin
      d_lo_n[wr_idx] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_up_q <= '0;
      d_lo_q <= '0;
      i_up_q <= '0;
      i_lo_q <= '0;
    end else if (wr_en) begin
      d_up_q <= d_up_n;
      d_lo_q <= d_lo_n;
      i_up_q <= i_up_n;
      i_lo_q <= i_lo_n;
    end
  end

  assign d_up = d_up_q;
  assign d_lo = d_lo_q;
  assign i_up = i_up_q;
  assign i_lo = i_lo_q;
endmodule

// File: rtl/bat_match.sv
module bat_match
  import bat_pkg::*;
(
  input  logic            en,
  input  tag_t            key,
  input  tag_t            base,
  input  tag_t            tgt,
  input  logic [BL_W-1:0] blen,
  output logic            hit,
  output tag_t            out_tag
);
  tag_t mask;

  always_comb begin
    mask    = tag_t'(blen);
    hit     = en && (((key ^ base) & ~mask) == '0);
    out_tag = (tgt & ~mask) | (key & mask);
  end
endmodule

// File: rtl/bat_pick.sv
module bat_pick #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N-1:0]        hit,
  input  logic [N-1:0][W-1:0] data,
  output logic                any,
  output logic [W-1:0]        sel
);
  always_comb begin
    any = |hit;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) sel = data[i];
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_instr,
  input  logic             wr_upper,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             lk_instr,
  input  logic             lk_super,
  input  logic             lk_store,
  input  logic [31:0]      lk_ea,
  output logic             lk_hit,
  output logic [31:0]      lk_pa,
  output logic [3:0]       lk_attr,
  output logic [1:0]       lk_prot,
  output logic             lk_fault,
  input  logic [31:0]      rv_pa,
  output logic             rv_hit,
  output logic [31:0]      rv_ea
);
  localparam int FW_W = TAG_W + ATTR_W + PROT_W;

  logic [N_ENT-1:0][ADDR_W-1:0] d_up, d_lo, i_up, i_lo;
  logic [N_ENT-1:0]             f_hit, r_hit;
  logic [N_ENT-1:0][FW_W-1:0]   f_data;
  logic [N_ENT-1:0][TAG_W-1:0]  r_data;
  logic [FW_W-1:0]              f_sel;
  logic [TAG_W-1:0]             r_sel;
  logic                         f_any, r_any;

  bat_regfile #(.N_ENT(N_ENT)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_instr(wr_instr),
    .wr_upper(wr_upper), .wr_idx(wr_idx), .wr_data(wr_data),
    .d_up(d_up), .d_lo(d_lo), .i_up(i_up), .i_lo(i_lo)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    word_t up_w, lo_w;
    tag_t  f_tag;
    assign up_w = lk_instr ? i_up[g] : d_up[g];
    assign lo_w = lk_instr ? i_lo[g] : d_lo[g];

    bat_match fwd_i (
      .en     (lk_super ? up_w[SV_BIT] : up_w[UV_BIT]),
      .key    (lk_ea[ADDR_W-1:OFS_W]),
      .base   (up_w[ADDR_W-1:OFS_W]),
      .tgt    (lo_w[ADDR_W-1:OFS_W]),
      .blen   (up_w[BL_LSB +: BL_W]),
      .hit    (f_hit[g]),
      .out_tag(f_tag)
    );
    assign f_data[g] = {f_tag, lo_w[ATTR_LSB +: ATTR_W], lo_w[PROT_W-1:0]};

    bat_match rev_i (
      .en     (d_up[g][SV_BIT] | d_up[g][UV_BIT]),
      .key    (rv_pa[ADDR_W-1:OFS_W]),
      .base   (d_lo[g][ADDR_W-1:OFS_W]),
      .tgt    (d_up[g][ADDR_W-1:OFS_W]),
      .blen   (d_up[g][BL_LSB +: BL_W]),
      .hit    (r_hit[g]),
      .out_tag(r_data[g])
    );
  end

  bat_pick #(.N(N_ENT), .W(FW_W))  fpick_i (.hit(f_hit), .data(f_data), .any(f_any), .sel(f_sel));
  bat_pick #(.N(N_ENT), .W(TAG_W)) rpick_i (.hit(r_hit), .data(r_data), .any(r_any), .sel(r_sel));

  always_comb begin
    lk_hit   = f_any;
    lk_pa    = f_any ? {f_sel[FW_W-1 -: TAG_W], lk_ea[OFS_W-1:0]} : '0;
    lk_attr  = f_any ? f_sel[PROT_W +: ATTR_W] : '0;
    lk_prot  = f_any ? f_sel[PROT_W-1:0] : '0;
    lk_fault = f_any && ((f_sel[PROT_W-1:0] == 2'b00) || (lk_store && f_sel[0]));
    rv_hit   = r_any;
    rv_ea    = r_any ? {r_sel, rv_pa[OFS_W-1:0]} : '0;
  end
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        lk_instr,
  input logic        lk_super,
  input logic        lk_store,
  input logic [31:0] lk_ea,
  input logic        lk_hit,
  input logic [31:0] lk_pa,
  input logic [3:0]  lk_attr,
  input logic [1:0]  lk_prot,
  input logic        lk_fault,
  input logic [31:0] rv_pa,
  input logic        rv_hit,
  input logic [31:0] rv_ea
);
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == 32'd0 && lk_attr == 4'd0 && lk_prot == 2'd0 && !lk_fault));

  assert_fault_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  assert_rw_no_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_prot == 2'b10) |-> !lk_fault);

  assert_instr_unguarded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_instr) |-> !lk_attr[0]);

  assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[16:0] == lk_ea[16:0]));

  assert_rev_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rv_hit |-> (rv_ea == 32'd0));

  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(lk_ea) && $stable(lk_super) && $stable(lk_instr)
     && $stable(rv_pa)) |-> ($stable(lk_hit) && $stable(lk_pa) && $stable(rv_ea)));
endmodule

bind bat_xlate bat_xlate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lk_instr(lk_instr),
  .lk_super(lk_super), .lk_store(lk_store), .lk_ea(lk_ea), .lk_hit(lk_hit),
  .lk_pa(lk_pa), .lk_attr(lk_attr), .lk_prot(lk_prot), .lk_fault(lk_fault),
  .rv_pa(rv_pa), .rv_hit(rv_hit), .rv_ea(rv_ea)
);

// File: tb/bat_xlate_tb.sv
module bat_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        wr_en, wr_instr, wr_upper;
  logic [1:0]  wr_idx;
  logic [31:0] wr_data;
  logic        lk_instr, lk_super, lk_store;
  logic [31:0] lk_ea, lk_pa, rv_pa, rv_ea;
  logic        lk_hit, lk_fault, rv_hit;
  logic [3:0]  lk_attr;
  logic [1:0]  lk_prot;

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit in_reset = 1;

  // reference state: [bank][entry], bank 0 data, bank 1 instruction
  bit [31:0] m_up [2][4];
  bit [31:0] m_lo [2][4];

  bat_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_instr(wr_instr),
    .wr_upper(wr_upper), .wr_idx(wr_idx), .wr_data(wr_data),
    .lk_instr(lk_instr), .lk_super(lk_super), .lk_store(lk_store), .lk_ea(lk_ea),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr), .lk_prot(lk_prot),
    .lk_fault(lk_fault), .rv_pa(rv_pa), .rv_hit(rv_hit), .rv_ea(rv_ea)
  );

  initial clk = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic longint region_size(bit [31:0] up);
    return (longint'(up[12:2]) + 1) << 17;
  endfunction

  task automatic compare();
    bit e_hit = 0, r_hit = 0, e_fault;
    bit [31:0] e_pa = 0, e_ea = 0;
    bit [3:0] e_attr = 0;
    bit [1:0] e_prot = 0;
    int b = lk_instr ? 1 : 0;
    for (int i = 0; i < 4; i++) begin
      bit on = lk_super ? m_up[b][i][1] : m_up[b][i][0];
      longint st = longint'(m_up[b][i][31:17]) << 17;
      if (!e_hit && on && longint'(lk_ea) >= st && longint'(lk_ea) <= st + region_size(m_up[b][i]) - 1) begin
        e_hit  = 1;
        e_pa   = 32'((longint'(m_lo[b][i][31:17]) << 17) + (longint'(lk_ea) - st));
        e_attr = m_lo[b][i][6:3];
        e_prot = m_lo[b][i][1:0];
      end
    end
    e_fault = e_hit && (e_prot == 2'b00 || (lk_store && e_prot[0]));
    for (int i = 0; i < 4; i++) begin
      bit on = m_up[0][i][1] | m_up[0][i][0];
      longint ps = longint'(m_lo[0][i][31:17]) << 17;
      if (!r_hit && on && longint'(rv_pa) >= ps && longint'(rv_pa) <= ps + region_size(m_up[0][i]) - 1) begin
        r_hit = 1;
        e_ea  = 32'((longint'(m_up[0][i][31:17]) << 17) + (longint'(rv_pa) - ps));
      end
    end
    check(lk_hit == e_hit, "lk_hit", lk_hit, e_hit);
    check(lk_pa == e_pa, "lk_pa", lk_pa, e_pa);
    check(lk_attr == e_attr, "lk_attr", lk_attr, e_attr);
    check(lk_prot == e_prot, "lk_prot", lk_prot, e_prot);
    check(lk_fault == e_fault, "lk_fault", lk_fault, e_fault);
    check(rv_hit == r_hit, "rv_hit", rv_hit, r_hit);
    check(rv_ea == e_ea, "rv_ea", rv_ea, e_ea);
  endtask

  // one clock: drive at falling edge, compare, then apply model write at rising edge
  task automatic cyc(input bit we, input bit wi, input bit wu, input int idx, input bit [31:0] wd,
                     input bit li, input bit ls, input bit st, input bit [31:0] ea, input bit [31:0] pa);
    @(negedge clk);
    wr_en = we; wr_instr = wi; wr_upper = wu; wr_idx = 2'(idx); wr_data = wd;
    lk_instr = li; lk_super = ls; lk_store = st; lk_ea = ea; rv_pa = pa;
    #1 compare();
    @(posedge clk);
    if (we && !in_reset) begin
      if (wi && !wu && wd[3]) begin
        m_up[1][idx] = 0; m_lo[1][idx] = 0;
      end else if (wu) m_up[wi][idx] = wd;
      else m_lo[wi][idx] = wd;
    end
  endtask

  task automatic wr(input bit wi, input int idx, input bit wu, input bit [31:0] wd);
    cyc(1, wi, wu, idx, wd, 0, 1, 0, 32'h0, 32'h0);
  endtask

  task automatic look(input bit li, input bit ls, input bit st, input bit [31:0] ea, input bit [31:0] pa);
    cyc(0, 0, 0, 0, 0, li, ls, st, ea, pa);
  endtask

  function automatic bit [31:0] up_word(bit [31:0] base, int bl, bit sv, bit uv);
    return (base & 32'hFFFE_0000) | (32'(bl) << 2) | {30'd0, sv, uv};
  endfunction

  function automatic bit [31:0] lo_word(bit [31:0] base, bit [3:0] attr, bit [1:0] prot);
    return (base & 32'hFFFE_0000) | (32'(attr) << 3) | 32'(prot);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 4; i++) begin m_up[b][i] = 0; m_lo[b][i] = 0; end
    rst_n = 0;
    wr_en = 0; wr_instr = 0; wr_upper = 0; wr_idx = 0; wr_data = 0;
    lk_instr = 0; lk_super = 0; lk_store = 0; lk_ea = 0; rv_pa = 0;

    // R1: reset holds everything invalid, even with a write strobe
    tag = "R1";
    cyc(1, 0, 1, 0, up_word(32'h0, 0, 1, 1), 0, 1, 0, 32'h0000_1000, 32'h0);
    look(0, 0, 0, 32'h0000_0000, 32'h0000_0000);
    @(negedge clk); rst_n = 1; in_reset = 0;
    look(0, 1, 0, 32'h0001_0000, 32'h0001_0000);

    // R2: write latency; entry 0 data: 1 MiB at EA 0x1000_0000 -> PA 0x0030_0000
    tag = "R2";
    wr(0, 0, 1, up_word(32'h1000_0000, 7, 1, 0));
    cyc(1, 0, 0, 0, lo_word(32'h0030_0000, 4'b0100, 2'b10), 0, 1, 0, 32'h1000_0040, 32'h0030_0040);
    look(0, 1, 0, 32'h1000_0040, 32'h0030_0040);

    // R3: attribute and protection fields
    tag = "R3";
    wr(0, 0, 0, lo_word(32'h0030_0000, 4'b1011, 2'b10));
    look(0, 1, 0, 32'h1008_1234, 32'h0);

    // R4: inclusive limits of a 1 MiB region
    tag = "R4";
    look(0, 1, 0, 32'h100F_FFFF, 32'h003F_FFFF);
    look(0, 1, 0, 32'h1010_0000, 32'h0040_0000);
    look(0, 1, 0, 32'h0FFF_FFFF, 32'h002F_FFFF);

    // R5: offset merge on a smallest region at entry 3
    tag = "R5";
    wr(0, 3, 1, up_word(32'hC002_0000, 0, 1, 1));
    wr(0, 3, 0, lo_word(32'h7FFE_0000, 4'b0010, 2'b01));
    look(0, 0, 0, 32'hC003_ABCD, 32'h7FFF_0001);
    look(0, 1, 0, 32'hC004_0000, 32'h7FFD_FFFF);

    // R6: mode gating (entry 0 supervisor only)
    tag = "R6";
    look(0, 0, 0, 32'h1000_0040, 32'h0);
    look(0, 1, 0, 32'h1000_0040, 32'h0);

    // R7: entry 1, 256 MiB overlapping entry 0
    tag = "R7";
    wr(0, 1, 1, up_word(32'h1000_0000, 2047, 1, 1));
    wr(0, 1, 0, lo_word(32'h8000_0000, 4'b0000, 2'b10));
    look(0, 1, 0, 32'h1000_8000, 32'h0030_0010);
    look(0, 0, 0, 32'h1000_8000, 32'h8000_0010);
    look(0, 1, 0, 32'h1FFF_FFFF, 32'h8FFF_FFFF);

    // R8: clear miss
    tag = "R8";
    look(0, 1, 1, 32'h2000_0000, 32'h4000_0000);

    // R9: instruction bank and guarded rule
    tag = "R9";
    wr(1, 2, 1, up_word(32'h4000_0000, 15, 1, 1));
    wr(1, 2, 0, lo_word(32'h0100_0000, 4'b0001, 2'b10));
    look(1, 1, 0, 32'h4000_1000, 32'h0);
    wr(1, 2, 1, up_word(32'h4000_0000, 15, 1, 1));
    wr(1, 2, 0, lo_word(32'h0100_0000, 4'b0100, 2'b01));
    look(1, 1, 0, 32'h4010_1000, 32'h0);
    look(0, 1, 0, 32'h4010_1000, 32'h0);

    // R10: protection codes
    tag = "R10";
    look(1, 1, 1, 32'h4000_0000, 32'h0);
    look(1, 1, 0, 32'h4000_0000, 32'h0);
    look(0, 1, 1, 32'h1000_0000, 32'h0);
    wr(0, 0, 0, lo_word(32'h0030_0000, 4'b0000, 2'b00));
    look(0, 1, 0, 32'h1000_0000, 32'h0);
    wr(0, 0, 0, lo_word(32'h0030_0000, 4'b0000, 2'b11));
    look(0, 1, 1, 32'h1000_0000, 32'h0);
    look(0, 1, 0, 32'h1000_0000, 32'h0);

    // R11: reverse lookup priority and miss
    tag = "R11";
    wr(0, 2, 1, up_word(32'hA000_0000, 1, 0, 1));
    wr(0, 2, 0, lo_word(32'h0030_0000, 4'b0000, 2'b10));
    look(0, 1, 0, 32'h0, 32'h0030_0080);
    look(0, 1, 0, 32'h0, 32'h8123_4567);
    look(0, 1, 0, 32'h0, 32'h9000_0000);

    // randomized reload and lookup mix
    tag = "R5";
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 7) == 0) begin
        int k = $urandom_range(0, 11);
        bit wi = 1'($urandom);
        int idx = $urandom_range(0, 3);
        bit [31:0] msk = ~((32'h1 << (17 + k)) - 1);
        tag = "R9";
        wr(wi, idx, 1, 32'h0);
        wr(wi, idx, 0, lo_word($urandom & msk, 4'($urandom), 2'($urandom)));
        wr(wi, idx, 1, up_word($urandom & msk, (1 << k) - 1, 1'($urandom), 1'($urandom)));
        tag = "R5";
      end else begin
        int e = $urandom_range(0, 3);
        int b = $urandom_range(0, 1);
        bit [31:0] ea = (m_up[b][e] & 32'hFFFE_0000) + 32'($urandom_range(0, 32'h0040_0000)) - 32'h0010_0000;
        bit [31:0] pa = (m_lo[0][e] & 32'hFFFE_0000) + 32'($urandom_range(0, 32'h0040_0000)) - 32'h0010_0000;
        look(1'(b), 1'($urandom), 1'($urandom), ea, pa);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule